// File: doc/BRIEF.md
# Prioritized Interrupt Entry and Return Sequencer

This block sits beside the core of a small 8-bit, page-addressed processor. It decides when a hardware interrupt is taken and runs the memory traffic that saves and restores the processor context. Three hardware sources are latched as pending requests: a timer-or-real-time source, a second timer and an external line. Each source has its own enable bit. A single mask flag blocks every hardware source while a handler runs. A software-interrupt strobe from the instruction path forces an entry whatever the mask and the pending state.

On entry the block writes four bytes into a stack in RAM that grows downward, one byte per cycle. It then hands the core a new program counter and program page from a fixed vector table. On a return strobe it reads the four bytes back in the opposite order, moving the stack pointer up before each read. It gives back the saved status byte first and the saved page and program counter last. A stop strobe parks the block until the external line rises.

The stack pointer lives in this block. The core reloads it through a write port. The stack RAM is outside the block, and its read data must be valid in the same cycle as the read strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the stack pointer is 00h, the mask flag is 0, `busy` and `sleeping` are 0, and no request is pending.
- R2: Enable bit 0 belongs to timer 0/real-time, bit 1 to timer 1 and bit 2 to the external line. Among enabled pending requests, timer 0/real-time wins over timer 1, and timer 1 wins over external. A request whose enable bit is 0 is not taken, but it stays pending until it is enabled.
- R3: An entry writes four bytes on four consecutive cycles, at addresses SP, SP-1, SP-2 and SP-3, in this order: PC bits 7:0, then {00, PC bits 13:8}, then {00, program page}, then the status byte. The stack pointer ends 4 lower.
- R4: The mask flag reads 1 from the first push cycle of any entry. While it is 1, no hardware entry starts, and requests stay latched as pending.
- R5: On the fourth push cycle, `pcLoad` pulses with page 3 and offset 3FF0h for timer 0/real-time, 3FE0h for timer 1, 3FD0h for external and 3FC0h for software.
- R6: A software strobe while idle starts an entry to 3:3FC0h even when the mask is 1 or hardware requests are pending. Those requests remain pending.
- R7: A return reads four bytes at SP+1, SP+2, SP+3 and SP+4 on consecutive cycles, and the pointer rises by one each cycle. The first byte is presented as the status on `psLoad`/`psNew`. On the fourth cycle, `pcLoad` gives page = second byte[5:0] and PC = {third byte[5:0], fourth byte}. The mask flag is 0 afterwards.
- R8: A stop strobe while idle sets `sleeping`. Only a high level on the raw external line, enabled or not, ends sleep. Other requests are latched during sleep but do not wake the block.
- R9: A serviced source's pending latch is cleared when its entry is accepted, so the same source does not enter again without a new request.
- R10: When strobes arrive together in the idle state, software entry takes precedence over return, return over stop, and stop over hardware entry.
- R11: `spWrEn` loads `spWrData` into the stack pointer when no push or pop is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 3 | Hardware request lines: [0] timer 0/real-time, [1] timer 1, [2] external |
| irqEn | input | 3 | Per-source enable bits, same bit order |
| swIntStb | input | 1 | Software interrupt strobe |
| retStb | input | 1 | Return-from-interrupt strobe |
| stopStb | input | 1 | Enter stop mode strobe |
| pcIn | input | 14 | Current program counter |
| pageIn | input | 6 | Current program page |
| statusIn | input | 8 | Current status byte |
| spWrEn | input | 1 | Stack pointer load strobe |
| spWrData | input | 8 | Stack pointer load value |
| stkRdata | input | 8 | Stack RAM read data, valid with stkRe |
| busy | output | 1 | Block is not idle (pushing, popping or asleep) |
| sleeping | output | 1 | Stop mode active |
| intMask | output | 1 | Interrupt mask flag |
| sp | output | 8 | Stack pointer |
| stkWe | output | 1 | Stack RAM write strobe |
| stkRe | output | 1 | Stack RAM read strobe |
| stkAddr | output | 8 | Stack RAM address |
| stkWdata | output | 8 | Stack RAM write data |
| pcLoad | output | 1 | Load pcNew and pageNew into the core |
| pcNew | output | 14 | New program counter |
| pageNew | output | 6 | New program and data page |
| psLoad | output | 1 | Load psNew into the status register |
| psNew | output | 8 | Restored status byte |

## Verification
A hardware request raised before a clock edge is latched at that edge. It is accepted one edge later, and the first stack write is visible in the cycle after acceptance. The remaining writes follow one per cycle, and `pcLoad` is due together with the fourth write. A software or return strobe is accepted on the first edge, so its first memory access shows in the next cycle. Because of this spread of latencies, a scoreboard holds the expected writes, status restores and vector loads in order, and a monitor compares them whenever the design raises a strobe. Direct checks of the mask, sleep and stack pointer are sampled on falling edges at fixed cycle counts after each stimulus. An idle wait requires three quiet cycles in a row, so that a back-to-back re-entry is not missed.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  // Hardware sources handled by the arbiter; slot 3 of the vector table is software.
  localparam int HW_SRC = 3;
  localparam int SLOTS = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP,
    ST_STOP
  } seqStateT;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic       snap;      // capture context and vector index
    logic [1:0] vecSel;    // vector slot to use on entry
    logic       push;      // stack write this cycle
    logic       pop;       // stack read this cycle
    logic [1:0] slot;      // context byte: 0 pcLo, 1 pcHi, 2 page, 3 status
    logic       loadEntry; // final push cycle: hand out vector
    logic       loadRet;   // final pop cycle: hand out restored PC/page
  } seqStrobeT;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int NHW = HW_SRC
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NHW-1:0]  irqReq,
  input  logic [NHW-1:0]  irqEn,
  input  logic            swIntStb,
  input  logic            retStb,
  input  logic            stopStb,
  output seqStrobeT       strobe,
  output logic            intMask,
  output logic            busy,
  output logic            sleeping
);
  localparam int EXT_IDX = NHW - 1;
  localparam int SW_SLOT = SLOTS - 1;

  seqStateT       state;
  logic [1:0]     cnt;
  logic [NHW-1:0] pend, ready, grant, clr;
  logic [1:0]     grantIdx;
  logic           takeSw, takeRet, takeStop, takeHw;

  // Lowest index wins: isolate the least significant ready bit.
  assign ready = pend & irqEn;
  assign grant = ready & (~ready + {{(NHW-1){1'b0}}, 1'b1});

  always_comb begin
    grantIdx = 2'd0;
    for (int i = NHW - 1; i >= 0; i--) begin
      if (grant[i]) grantIdx = 2'(i);
    end
  end

  assign takeSw   = (state == ST_IDLE) && swIntStb;
  assign takeRet  = (state == ST_IDLE) && retStb && !swIntStb;
  assign takeStop = (state == ST_IDLE) && stopStb && !swIntStb && !retStb;
  assign takeHw   = (state == ST_IDLE) && !swIntStb && !retStb && !stopStb &&
                    !intMask && (|ready);
  assign clr      = takeHw ? grant : '0;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else       pend <= (pend & ~clr) | irqReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= 2'd0;
      intMask <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= 2'd0;
          if (takeSw || takeHw) begin
            state   <= ST_PUSH;
            intMask <= 1'b1;
          end else if (takeRet) begin
            state <= ST_POP;
          end else if (takeStop) begin
            state <= ST_STOP;
          end
        end
        ST_PUSH: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) state <= ST_IDLE;
        end
        ST_POP: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            state   <= ST_IDLE;
            intMask <= 1'b0;
          end
        end
        ST_STOP: begin
          if (irqReq[EXT_IDX]) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.snap      = takeSw || takeHw;
    strobe.vecSel    = takeSw ? 2'(SW_SLOT) : grantIdx;
    strobe.push      = (state == ST_PUSH);
    strobe.pop       = (state == ST_POP);
    strobe.slot      = (state == ST_POP) ? ~cnt : cnt;
    strobe.loadEntry = (state == ST_PUSH) && (cnt == 2'd3);
    strobe.loadRet   = (state == ST_POP) && (cnt == 2'd3);
  end

  assign busy     = (state != ST_IDLE);
  assign sleeping = (state == ST_STOP);

  AST_MASK_DURING_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PUSH) |-> intMask); // R4
  AST_MASKED_NO_HW_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && intMask && !swIntStb) |=> (state != ST_PUSH)); // R4
  AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (takeHw && ready[0]) |-> (clr == {{(NHW-1){1'b0}}, 1'b1})); // R2
  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (takeHw && ((grant & irqReq) == '0)) |=> ((pend & $past(grant)) == '0)); // R9
  AST_WAKE_ON_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && irqReq[EXT_IDX]) |=> (state == ST_IDLE)); // R8
  AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && !irqReq[EXT_IDX]) |=> (state == ST_STOP)); // R8
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          PCW      = 14,
  parameter int          PGW      = 6,
  parameter int unsigned VEC_PAGE = 3,
  parameter int unsigned VEC_TOP  = 'h3FF0,
  parameter int unsigned VEC_STEP = 'h10
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobeT      strobe,
  input  logic [PCW-1:0] pcIn,
  input  logic [PGW-1:0] pageIn,
  input  logic [DW-1:0]  statusIn,
  input  logic           spWrEn,
  input  logic [DW-1:0]  spWrData,
  input  logic [DW-1:0]  stkRdata,
  output logic [DW-1:0]  sp,
  output logic           stkWe,
  output logic           stkRe,
  output logic [DW-1:0]  stkAddr,
  output logic [DW-1:0]  stkWdata,
  output logic           pcLoad,
  output logic [PCW-1:0] pcNew,
  output logic [PGW-1:0] pageNew,
  output logic           psLoad,
  output logic [DW-1:0]  psNew
);
  localparam int PCH_W = PCW - DW;

  logic [PCW-1:0]   pcSnap;
  logic [PGW-1:0]   pageSnap;
  logic [DW-1:0]    psSnap;
  logic [1:0]       vecReg;
  logic [PGW-1:0]   pgHold;
  logic [PCH_W-1:0] pchHold;
  logic [PCW-1:0]   vecTab [SLOTS];

  // Vector offsets step down from the top slot by a fixed stride.
  for (genvar g = 0; g < SLOTS; g++) begin : gVec
    assign vecTab[g] = PCW'(VEC_TOP - VEC_STEP * g);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            sp <= '0;
    else if (strobe.push) sp <= sp - 1'b1;
    else if (strobe.pop)  sp <= sp + 1'b1;
    else if (spWrEn)      sp <= spWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcSnap   <= '0;
      pageSnap <= '0;
      psSnap   <= '0;
      vecReg   <= '0;
    end else if (strobe.snap) begin
      pcSnap   <= pcIn;
      pageSnap <= pageIn;
      psSnap   <= statusIn;
      vecReg   <= strobe.vecSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pgHold  <= '0;
      pchHold <= '0;
    end else if (strobe.pop) begin
      if (strobe.slot == 2'd2) pgHold  <= stkRdata[PGW-1:0];
      if (strobe.slot == 2'd1) pchHold <= stkRdata[PCH_W-1:0];
    end
  end

  assign stkWe   = strobe.push;
  assign stkRe   = strobe.pop;
  assign stkAddr = strobe.pop ? sp + 1'b1 : sp;

  always_comb begin
    unique case (strobe.slot)
      2'd0:    stkWdata = pcSnap[DW-1:0];
      2'd1:    stkWdata = {{(DW-PCH_W){1'b0}}, pcSnap[PCW-1:DW]};
      2'd2:    stkWdata = {{(DW-PGW){1'b0}}, pageSnap};
      default: stkWdata = psSnap;
    endcase
  end

  assign pcLoad  = strobe.loadEntry || strobe.loadRet;
  assign pcNew   = strobe.loadRet ? {pchHold, stkRdata} : vecTab[vecReg];
  assign pageNew = strobe.loadRet ? pgHold : PGW'(VEC_PAGE);
  assign psLoad  = strobe.pop && (strobe.slot == 2'd3);
  assign psNew   = stkRdata;

  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.push && strobe.pop)); // R3
  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> (sp == $past(sp) - 1'b1)); // R3
  AST_POP_ASCENDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> (sp == $past(sp) + 1'b1)); // R7
  AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (spWrEn && !strobe.push && !strobe.pop) |=> (sp == $past(spWrData))); // R11
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          PCW      = 14,
  parameter int          PGW      = 6,
  parameter int          NHW      = HW_SRC,
  parameter int unsigned VEC_PAGE = 3,
  parameter int unsigned VEC_TOP  = 'h3FF0,
  parameter int unsigned VEC_STEP = 'h10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NHW-1:0] irqReq,
  input  logic [NHW-1:0] irqEn,
  input  logic           swIntStb,
  input  logic           retStb,
  input  logic           stopStb,
  input  logic [PCW-1:0] pcIn,
  input  logic [PGW-1:0] pageIn,
  input  logic [DW-1:0]  statusIn,
  input  logic           spWrEn,
  input  logic [DW-1:0]  spWrData,
  input  logic [DW-1:0]  stkRdata,
  output logic           busy,
  output logic           sleeping,
  output logic           intMask,
  output logic [DW-1:0]  sp,
  output logic           stkWe,
  output logic           stkRe,
  output logic [DW-1:0]  stkAddr,
  output logic [DW-1:0]  stkWdata,
  output logic           pcLoad,
  output logic [PCW-1:0] pcNew,
  output logic [PGW-1:0] pageNew,
  output logic           psLoad,
  output logic [DW-1:0]  psNew
);
  seqStrobeT strobe;

  irq_seq_ctrl #(.NHW(NHW)) uCtrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEn(irqEn),
    .swIntStb(swIntStb), .retStb(retStb), .stopStb(stopStb),
    .strobe(strobe), .intMask(intMask), .busy(busy), .sleeping(sleeping)
  );

  irq_seq_dp #(
    .DW(DW), .PCW(PCW), .PGW(PGW),
    .VEC_PAGE(VEC_PAGE), .VEC_TOP(VEC_TOP), .VEC_STEP(VEC_STEP)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pcIn(pcIn), .pageIn(pageIn), .statusIn(statusIn),
    .spWrEn(spWrEn), .spWrData(spWrData), .stkRdata(stkRdata),
    .sp(sp), .stkWe(stkWe), .stkRe(stkRe), .stkAddr(stkAddr),
    .stkWdata(stkWdata), .pcLoad(pcLoad), .pcNew(pcNew),
    .pageNew(pageNew), .psLoad(psLoad), .psNew(psNew)
  );
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  irqReq = '0, irqEn = '0;
  logic        swIntStb = 1'b0, retStb = 1'b0, stopStb = 1'b0;
  logic [13:0] pcIn = 14'h1234;
  logic [5:0]  pageIn = 6'h05;
  logic [7:0]  statusIn = 8'hA5;
  logic        spWrEn = 1'b0;
  logic [7:0]  spWrData = '0;
  logic [7:0]  stkRdata;
  logic        busy, sleeping, intMask, stkWe, stkRe, pcLoad, psLoad;
  logic [7:0]  sp, stkAddr, stkWdata, psNew;
  logic [13:0] pcNew;
  logic [5:0]  pageNew;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEn(irqEn),
    .swIntStb(swIntStb), .retStb(retStb), .stopStb(stopStb),
    .pcIn(pcIn), .pageIn(pageIn), .statusIn(statusIn),
    .spWrEn(spWrEn), .spWrData(spWrData), .stkRdata(stkRdata),
    .busy(busy), .sleeping(sleeping), .intMask(intMask), .sp(sp),
    .stkWe(stkWe), .stkRe(stkRe), .stkAddr(stkAddr), .stkWdata(stkWdata),
    .pcLoad(pcLoad), .pcNew(pcNew), .pageNew(pageNew),
    .psLoad(psLoad), .psNew(psNew)
  );

  // Stack RAM model with same-cycle read data.
  logic [7:0] ram [256];
  always @(posedge clk) if (stkWe) ram[stkAddr] <= stkWdata;
  assign stkRdata = ram[stkAddr];

  // Scoreboard: kind 0 = stack write, 1 = PC/page load, 2 = status restore.
  typedef struct {
    int         kind;
    logic [7:0] addr;
    logic [19:0] val;
    string      tag;
  } itemT;
  itemT expQ[$];
  logic [7:0] expStack [256];
  logic [7:0] expSp = 8'h00;

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic addItem(input int kind, input logic [7:0] addr, input logic [19:0] val, input string tag);
    itemT it;
    it.kind = kind; it.addr = addr; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic expectEntry(input logic [13:0] off, input string tag);
    logic [7:0] bytes [4];
    bytes[0] = pcIn[7:0];
    bytes[1] = {2'b00, pcIn[13:8]};
    bytes[2] = {2'b00, pageIn};
    bytes[3] = statusIn;
    for (int i = 0; i < 4; i++) begin
      addItem(0, expSp, {12'h0, bytes[i]}, {tag, " push (R3)"});
      expStack[expSp] = bytes[i];
      expSp = expSp - 8'd1;
    end
    addItem(1, 8'h0, {6'd3, off}, {tag, " vector (R5)"});
  endtask

  task automatic expectReturn(input string tag);
    logic [7:0] ps, pg, pch, pcl;
    expSp = expSp + 8'd1; ps  = expStack[expSp];
    expSp = expSp + 8'd1; pg  = expStack[expSp];
    expSp = expSp + 8'd1; pch = expStack[expSp];
    expSp = expSp + 8'd1; pcl = expStack[expSp];
    addItem(2, 8'h0, {12'h0, ps}, {tag, " status restore (R7)"});
    addItem(1, 8'h0, {pg[5:0], pch[5:0], pcl}, {tag, " pc restore (R7)"});
  endtask

  task automatic compareEvt(input int kind, input logic [7:0] addr, input logic [19:0] val);
    itemT it;
    if (expQ.size() == 0) begin
      check(1'b0, "unexpected event R3 R7", {12'h0, addr}, 20'h0);
    end else begin
      it = expQ.pop_front();
      check(it.kind == kind && it.addr == addr && it.val == val, it.tag,
            (kind == 0) ? {addr, val[11:0]} : val,
            (it.kind == 0) ? {it.addr, it.val[11:0]} : it.val);
    end
  endtask

  // Monitor samples on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (stkWe)  compareEvt(0, stkAddr, {12'h0, stkWdata});
      if (psLoad) compareEvt(2, 8'h0, {12'h0, psNew});
      if (pcLoad) compareEvt(1, 8'h0, {pageNew, pcNew});
    end
  end

  task automatic pulseIrq(input logic [2:0] m);
    @(negedge clk) irqReq = m;
    @(negedge clk) irqReq = '0;
  endtask

  task automatic pulseSw;
    @(negedge clk) swIntStb = 1'b1;
    @(negedge clk) swIntStb = 1'b0;
  endtask

  task automatic pulseRet;
    @(negedge clk) retStb = 1'b1;
    @(negedge clk) retStb = 1'b0;
  endtask

  task automatic waitIdle;
    int quiet = 0;
    repeat (2) @(negedge clk);
    while (quiet < 3) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sp == 8'h00, "R1 sp after reset", {12'h0, sp}, 20'h0);
    check(!intMask && !busy && !sleeping, "R1 flags after reset",
          {17'h0, intMask, busy, sleeping}, 20'h0);

    // R11 load stack pointer
    @(negedge clk) begin spWrEn = 1'b1; spWrData = 8'hFF; end
    @(negedge clk) spWrEn = 1'b0;
    check(sp == 8'hFF, "R11 sp load", {12'h0, sp}, 20'hFF);
    expSp = 8'hFF;
    irqEn = 3'b111;

    // Single timer 1 request
    expectEntry(14'h3FE0, "t1 entry");
    pulseIrq(3'b010);
    waitIdle();
    check(intMask == 1'b1, "R4 mask after entry", {19'h0, intMask}, 20'h1);
    check(sp == 8'hFB, "R3 sp after entry", {12'h0, sp}, 20'hFB);

    // Masked: timer 0 request must wait
    pcIn = 14'h0ABC; pageIn = 6'h2A; statusIn = 8'h3C;
    pulseIrq(3'b001);
    repeat (6) @(negedge clk);
    check(!busy, "R4 masked request not taken", {19'h0, busy}, 20'h0);
    expectReturn("t1 return");
    expectEntry(14'h3FF0, "pending t0 entry after unmask R4");
    pulseRet();
    waitIdle();
    check(sp == 8'hFB, "R4 R7 sp after return plus entry", {12'h0, sp}, 20'hFB);
    expectReturn("t0 return");
    pulseRet();
    waitIdle();
    check(!intMask, "R7 mask cleared", {19'h0, intMask}, 20'h0);
    check(sp == 8'hFF, "R7 sp restored", {12'h0, sp}, 20'hFF);
    repeat (5) @(negedge clk);
    check(!busy, "R9 serviced source not re-entered", {19'h0, busy}, 20'h0);

    // All three at once: priority order
    pcIn = 14'h2001; pageIn = 6'h11; statusIn = 8'h81;
    expectEntry(14'h3FF0, "R2 first t0");
    pulseIrq(3'b111);
    waitIdle();
    expectReturn("R2 ret1");
    expectEntry(14'h3FE0, "R2 second t1");
    pulseRet();
    waitIdle();
    expectReturn("R2 ret2");
    expectEntry(14'h3FD0, "R2 third ext");
    pulseRet();
    waitIdle();
    expectReturn("R2 ret3");
    pulseRet();
    waitIdle();
    check(sp == 8'hFF && !intMask, "R2 R9 all serviced", {11'h0, intMask, sp}, 20'hFF);

    // Disabled source stays pending
    irqEn = 3'b101;
    pulseIrq(3'b010);
    repeat (6) @(negedge clk);
    check(!busy, "R2 disabled source not taken", {19'h0, busy}, 20'h0);
    expectEntry(14'h3FE0, "R2 pending t1 once enabled");
    irqEn = 3'b111;
    waitIdle();
    expectReturn("R2 pending t1 return");
    pulseRet();
    waitIdle();

    // Software with pending hardware, then nested software while masked
    pcIn = 14'h0101; pageIn = 6'h01; statusIn = 8'h10;
    expectEntry(14'h3FC0, "R6 R10 sw over hw");
    @(negedge clk) begin swIntStb = 1'b1; irqReq = 3'b010; end
    @(negedge clk) begin swIntStb = 1'b0; irqReq = '0; end
    check(intMask == 1'b1, "R4 mask on first push cycle", {19'h0, intMask}, 20'h1);
    waitIdle();
    pcIn = 14'h3F02; pageIn = 6'h3E; statusIn = 8'hE7;
    expectEntry(14'h3FC0, "R6 sw while masked");
    pulseSw();
    waitIdle();
    check(sp == 8'hF7, "R6 sp after nested entries", {12'h0, sp}, 20'hF7);
    expectReturn("R6 inner return");
    expectEntry(14'h3FE0, "R6 t1 kept pending");
    pulseRet();
    waitIdle();
    expectReturn("R6 t1 return");
    pulseRet();
    waitIdle();
    // R10 return beats stop
    expectReturn("R10 ret over stop");
    @(negedge clk) begin retStb = 1'b1; stopStb = 1'b1; end
    @(negedge clk) begin retStb = 1'b0; stopStb = 1'b0; end
    check(!sleeping, "R10 return taken, not stop", {19'h0, sleeping}, 20'h0);
    waitIdle();
    check(sp == 8'hFF && !intMask, "R7 all frames popped", {11'h0, intMask, sp}, 20'hFF);

    // Stop mode
    irqEn = 3'b001;
    @(negedge clk) stopStb = 1'b1;
    @(negedge clk) stopStb = 1'b0;
    check(sleeping, "R8 enters stop", {19'h0, sleeping}, 20'h1);
    pulseIrq(3'b001);
    repeat (4) @(negedge clk);
    check(sleeping, "R8 timer does not wake", {19'h0, sleeping}, 20'h1);
    expectEntry(14'h3FF0, "R8 pending t0 after wake");
    pulseIrq(3'b100);
    check(!sleeping, "R8 external wakes even when disabled", {19'h0, sleeping}, 20'h0);
    waitIdle();
    expectReturn("R8 return");
    pulseRet();
    waitIdle();

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3 R7 all expected events seen", expQ.size(), 20'h0);
    summary();
    $finish;
  end
endmodule